// File: doc/BRIEF.md
# Annealed Coupling-Weight Scale Generator

This block drives one shared gain that an asynchronous binary recurrent optimizer applies to all of its neuron-to-neuron coupling weights. The gain starts at zero when a run begins, so the first neuron decisions see only the bias terms. It then climbs toward full strength, one step per epoch, along an open-loop schedule. The bias weights never pass through this gain. The schedule depends only on settings captured at the start of the run and never on neuron states or network energy.

Two curve shapes can be selected. The exponential shape approaches full strength as 1 − e^(−t/τ) and is computed recursively in fixed point with a rate constant near 1/τ. The linear shape adds a constant increment each epoch and saturates at full strength. A run-length setting fixes how many epochs the run lasts. When that count is reached, the gain is forced to full strength and a done flag is raised.

Top module: `hop_anneal_scale`

## Requirements
- R1: After reset, scale_o is 0 and done_o is 0. Epoch strobes given before the first start pulse leave both unchanged.
- R2: A start pulse sets scale_o to 0, clears done_o and zeroes the epoch count one cycle later. This holds even in the middle of a run or after done. A start pulse in the same cycle as a strobe overrides the strobe.
- R3: In exponential mode (mode_i = 0), each accepted strobe that is not the last one of the run sets scale_o to s + floor((65535 − s) · rate / 65536), where s is the previous scale in Q0.16.
- R4: In linear mode (mode_i = 1), each accepted strobe that is not the last one of the run sets scale_o to min(s + rate, 65535).
- R5: On the strobe that brings the epoch count equal to the run length, scale_o becomes 65535 (full strength) and done_o becomes 1 in the following cycle.
- R6: While done_o is 1, further strobes change neither scale_o nor done_o.
- R7: mode_i, rate_i and run_len_i are sampled only on the start pulse. Changes to them during a run have no effect on the schedule.
- R8: A start pulse with run_len_i = 0 gives done_o = 1 and scale_o = 65535 one cycle later.
- R9: In cycles with no strobe and no start pulse, scale_o holds its value.
- R10: Between start pulses, scale_o never decreases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a new run; captures the settings |
| epoch_adv_i | input | 1 | One-cycle strobe that advances the schedule by one epoch |
| mode_i | input | 1 | Curve shape: 0 exponential, 1 linear |
| rate_i | input | 16 | Q0.16 rate (exponential) or increment (linear) |
| run_len_i | input | 16 | Number of epochs in the run |
| scale_o | output | 16 | Q0.16 coupling gain, 65535 is full strength |
| done_o | output | 1 | Run length reached |

## Verification
The embedded properties run on every cycle. They cover the following: the gain holds between strobes, the gain never falls within a run, a start pulse clears the state, done stays set once raised, done always comes with full gain, and the epoch count never passes the run length. Only the bench scenarios can show the exact per-epoch values of both curve shapes, including saturation of the linear ramp. The same is true for settings being captured at start and ignored afterwards, and for the zero-length run.

// File: rtl/hop_anneal_pkg.sv
package hop_anneal_pkg;
  typedef enum logic {
    SCH_EXP = 1'b0,
    SCH_LIN = 1'b1
  } sched_mode_e;
endpackage

// File: rtl/hop_epoch_ctr.sv
module hop_epoch_ctr #(
  parameter int EPOCH_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               adv_i,
  input  logic [EPOCH_W-1:0] len_i,
  output logic               step_o,
  output logic               last_o,
  output logic               done_o
);
  logic [EPOCH_W-1:0] ep_q, ep_d, len_q, len_d, ep_inc;
  logic               run_q, run_d, done_q, done_d;
  logic               en;

  assign step_o = run_q & ~done_q & adv_i & ~start_i;
  assign ep_inc = ep_q + EPOCH_W'(1);
  assign last_o = step_o & (ep_inc == len_q);
  assign done_o = done_q;
  assign en     = start_i | step_o;

  always_comb begin
    ep_d   = ep_q;
    len_d  = len_q;
    run_d  = run_q;
    done_d = done_q;
    if (start_i) begin
      ep_d   = '0;
      len_d  = len_i;
      run_d  = 1'b1;
      done_d = (len_i == '0);
    end else if (step_o) begin
      ep_d = ep_inc;
      if (last_o) done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ep_q   <= '0;
      len_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (en) begin
      ep_q   <= ep_d;
      len_q  <= len_d;
      run_q  <= run_d;
      done_q <= done_d;
    end
  end

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done_q && !start_i |=> done_q); // R6
  AST_EPOCH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && (len_q != '0) |-> ep_q <= len_q); // R5
endmodule

// File: rtl/hop_scale_step.sv
module hop_scale_step
  import hop_anneal_pkg::*;
#(
  parameter int SCALE_W = 16
) (
  input  sched_mode_e        mode_i,
  input  logic [SCALE_W-1:0] scale_i,
  input  logic [SCALE_W-1:0] rate_i,
  output logic [SCALE_W-1:0] scale_o
);
  localparam logic [SCALE_W-1:0] FULL = {SCALE_W{1'b1}};

  logic [2*SCALE_W-1:0] prod;
  logic [SCALE_W-1:0]   gap, exp_nxt, lin_nxt;
  logic [SCALE_W:0]     lin_sum;

  assign gap     = FULL - scale_i;
  assign prod    = {{SCALE_W{1'b0}}, gap} * {{SCALE_W{1'b0}}, rate_i};
  assign exp_nxt = scale_i + prod[2*SCALE_W-1:SCALE_W];
  assign lin_sum = {1'b0, scale_i} + {1'b0, rate_i};
  assign lin_nxt = lin_sum[SCALE_W] ? FULL : lin_sum[SCALE_W-1:0];

  always_comb begin
    case (mode_i)
      SCH_LIN: scale_o = lin_nxt;
      default: scale_o = exp_nxt;
    endcase
  end
endmodule

// File: rtl/hop_anneal_scale.sv
module hop_anneal_scale
  import hop_anneal_pkg::*;
#(
  parameter int SCALE_W = 16,
  parameter int EPOCH_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               epoch_adv_i,
  input  logic               mode_i,
  input  logic [SCALE_W-1:0] rate_i,
  input  logic [EPOCH_W-1:0] run_len_i,
  output logic [SCALE_W-1:0] scale_o,
  output logic               done_o
);
  localparam logic [SCALE_W-1:0] FULL = {SCALE_W{1'b1}};

  sched_mode_e        mode_q, mode_d;
  logic [SCALE_W-1:0] rate_q, rate_d;
  logic [SCALE_W-1:0] scale_q, scale_d, scale_step;
  logic               step, last, done;
  logic               en;

  hop_epoch_ctr #(.EPOCH_W(EPOCH_W)) i_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(start_i),
    .adv_i  (epoch_adv_i),
    .len_i  (run_len_i),
    .step_o (step),
    .last_o (last),
    .done_o (done)
  );

  hop_scale_step #(.SCALE_W(SCALE_W)) i_step (
    .mode_i (mode_q),
    .scale_i(scale_q),
    .rate_i (rate_q),
    .scale_o(scale_step)
  );

  assign en = start_i | step;

  always_comb begin
    mode_d  = mode_q;
    rate_d  = rate_q;
    scale_d = scale_q;
    if (start_i) begin
      mode_d  = sched_mode_e'(mode_i);
      rate_d  = rate_i;
      scale_d = (run_len_i == '0) ? FULL : '0;
    end else if (last) begin
      scale_d = FULL;
    end else if (step) begin
      scale_d = scale_step;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= SCH_EXP;
      rate_q  <= '0;
      scale_q <= '0;
    end else if (en) begin
      mode_q  <= mode_d;
      rate_q  <= rate_d;
      scale_q <= scale_d;
    end
  end

  assign scale_o = scale_q;
  assign done_o  = done;

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i && !epoch_adv_i |=> $stable(scale_q)); // R9
  AST_NO_DECREASE: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> scale_q >= $past(scale_q)); // R10
  AST_START_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && (run_len_i != '0) |=> (scale_q == '0) && !done); // R2
  AST_DONE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> scale_q == FULL); // R5
endmodule

// File: tb/test_hop_anneal_scale.sv
module test_hop_anneal_scale;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] FULL = 16'hFFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        epoch_adv_i = 1'b0;
  logic        mode_i = 1'b0;
  logic [15:0] rate_i = '0;
  logic [15:0] run_len_i = '0;
  logic [15:0] scale_o;
  logic        done_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hop_anneal_scale i_hop_anneal_scale (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .epoch_adv_i(epoch_adv_i),
    .mode_i(mode_i), .rate_i(rate_i), .run_len_i(run_len_i),
    .scale_o(scale_o), .done_o(done_o)
  );

  function automatic logic [15:0] m_exp(logic [15:0] s, logic [15:0] k);
    logic [31:0] p;
    p = {16'h0, FULL - s} * {16'h0, k};
    return s + p[31:16];
  endfunction

  function automatic logic [15:0] m_lin(logic [15:0] s, logic [15:0] k);
    logic [16:0] t;
    t = {1'b0, s} + {1'b0, k};
    return t[16] ? FULL : t[15:0];
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic adv();
    @(negedge clk) epoch_adv_i = 1'b1;
    @(negedge clk) epoch_adv_i = 1'b0;
  endtask

  task automatic go(logic m, logic [15:0] k, logic [15:0] len);
    @(negedge clk);
    mode_i = m; rate_i = k; run_len_i = len; start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 scale", scale_o, 16'h0);
    check("R1 done", {15'h0, done_o}, 16'h0);
    adv(); adv();
    check("R1 scale after strobe", scale_o, 16'h0);
    check("R1 done after strobe", {15'h0, done_o}, 16'h0);
  endtask

  task automatic t_exp();
    logic [15:0] s;
    go(1'b0, 16'h0666, 16'd12);
    check("R2 start scale", scale_o, 16'h0);
    s = '0;
    for (int i = 1; i < 12; i++) begin
      adv();
      s = m_exp(s, 16'h0666);
      check("R3 exp step", scale_o, s);
      check("R10 not done", {15'h0, done_o}, 16'h0);
    end
    repeat (3) @(negedge clk);
    check("R9 hold", scale_o, s);
    adv();
    check("R5 full", scale_o, FULL);
    check("R5 done", {15'h0, done_o}, 16'h1);
    adv(); adv();
    check("R6 scale kept", scale_o, FULL);
    check("R6 done kept", {15'h0, done_o}, 16'h1);
  endtask

  task automatic t_lin();
    go(1'b1, 16'h4000, 16'd10);
    adv(); check("R4 lin 1", scale_o, 16'h4000);
    adv(); check("R4 lin 2", scale_o, 16'h8000);
    adv(); check("R4 lin 3", scale_o, 16'hC000);
    adv(); check("R4 lin sat", scale_o, m_lin(16'hC000, 16'h4000));
    adv(); check("R4 lin stay", scale_o, FULL);
    check("R4 not done", {15'h0, done_o}, 16'h0);
  endtask

  task automatic t_latch();
    go(1'b0, 16'h2000, 16'd3);
    mode_i = 1'b1; rate_i = 16'h0100; run_len_i = 16'd100;
    adv(); check("R7 first step", scale_o, m_exp(16'h0, 16'h2000));
    adv(); check("R7 second step", scale_o, m_exp(m_exp(16'h0, 16'h2000), 16'h2000));
    adv();
    check("R7 length kept", {15'h0, done_o}, 16'h1);
    check("R7 full", scale_o, FULL);
  endtask

  task automatic t_restart();
    go(1'b1, 16'h1000, 16'd50);
    adv(); adv();
    check("R4 before restart", scale_o, 16'h2000);
    @(negedge clk);
    start_i = 1'b1; epoch_adv_i = 1'b1; mode_i = 1'b1; rate_i = 16'h0800; run_len_i = 16'd2;
    @(negedge clk) begin start_i = 1'b0; epoch_adv_i = 1'b0; end
    check("R2 restart scale", scale_o, 16'h0);
    check("R2 restart done", {15'h0, done_o}, 16'h0);
    adv(); check("R2 count zeroed", scale_o, 16'h0800);
    adv(); check("R5 short run", {15'h0, done_o}, 16'h1);
  endtask

  task automatic t_zero();
    go(1'b0, 16'h1000, 16'd0);
    check("R8 full", scale_o, FULL);
    check("R8 done", {15'h0, done_o}, 16'h1);
    adv();
    check("R8 stays", scale_o, FULL);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_exp();
    t_lin();
    t_latch();
    t_restart();
    t_zero();
    repeat (2) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule